// File: doc/BRIEF.md
# Trimmed One-Hertz Tick Divider

This block turns a nominal 32.768 kHz timekeeping clock into a one-cycle-per-second tick. The tick can be tuned to far below one part per million. The divider counts a programmable number of input cycles per tick. A window counter groups the ticks into fixed correction windows of 1023 seconds by default. At the start of each window, a small controller swallows a programmed number of input cycles before counting resumes. This stretches the first second of the window by that many clocks, which removes the surplus of a fast crystal. Only whole clocks can be removed, so any fractional part of the needed correction is left as residual error. That error is below one clock per window, which is about 0.03 ppm.

Software writes a divider value and a 10-bit deletion count through a simple write port. Both values sit in shadow registers and are copied into use when the next window starts, so a window never mixes two settings. The deletion controller has two states. `TS_PASS` lets every input cycle reach the divider. `TS_DELETE` blocks one input cycle per clock and spends one unit of the deletion budget each time. The controller moves from `TS_PASS` to `TS_DELETE` on a window start when trimming is enabled and the deletion count is non-zero. It moves from `TS_DELETE` back to `TS_PASS` on the clock that spends the last unit of the budget.

Top module: `rtc_trim_div`

## Requirements
- R1: During and right after reset, `hz_tick` and `win_mark` are low. The divider holds `DIV_RESET`, the deletion count holds 0 and the window tick count starts at 0.
- R2: When no cycles are being deleted, `hz_tick` is a single-cycle pulse once every `div` input cycles, where `div` is the active divider. The first pulse comes `div` cycles after reset release.
- R3: `win_mark` pulses only together with `hz_tick`, and only on every `WIN_TICKS`-th tick (1023 by default). Between two marks there are exactly `WIN_TICKS` ticks.
- R4: On the clock after a window-closing tick, the block removes D input cycles (D is the deletion count). The first tick of the new window is therefore spaced `div` + D cycles after the previous tick. The remaining ticks of that window are spaced `div` cycles apart.
- R5: The deletion count is a 10-bit value. A count of 0 removes no cycles.
- R6: When `trim_en` is low on the window-closing clock, the next window removes no cycles, whatever the stored count is.
- R7: A register write changes nothing in the current window. The written value applies from the next window start on. A write that lands on the window-closing clock itself applies from the window after that.
- R8: A divider write with a value below 2 is ignored, and the stored divider keeps its previous value.
- R9: When `wr_sel` = 0, the write loads the divider from all of `wr_data`. When `wr_sel` = 1, the write loads the deletion count from `wr_data[9:0]`, and the upper bits of `wr_data` are ignored.
- R10: The input-cycle counter stays below the active divider, and the window counter stays below `WIN_TICKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping clock, nominally 32768 cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = divider, 1 = deletion count |
| wr_data | input | DIV_W | Write data |
| trim_en | input | 1 | Allows deletion in the next window; sampled on the window-closing clock |
| hz_tick | output | 1 | One-cycle pulse per second |
| win_mark | output | 1 | One-cycle pulse on the tick that closes a correction window |

## Verification
The hardest case to reach is the effect of a new setting at a window boundary. With the default parameters, a window lasts more than 33 million input cycles, and only the first second of each window shows the deletion. The bench therefore shrinks the window to four ticks and drives the divider down to values between 2 and 7. In every window it writes the settings for the next one, sweeping every divider from 2 to 5 against every deletion count from 0 to 3. It also covers rejected divider values, a disabled trim, and junk in the upper data bits. For each tick, the bench works out the expected spacing and mark from the value that should be active in that window.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    // Deletion controller states
    typedef enum logic [0:0] {
        TS_PASS   = 1'b0,
        TS_DELETE = 1'b1
    } trim_state_e;

    // Write-port target select
    localparam logic SEL_DIVIDER = 1'b0;
    localparam logic SEL_DELETE  = 1'b1;

    // Smallest divider the block accepts
    localparam int MIN_DIV = 2;

endpackage

// File: rtl/rtc_trim_cfg.sv
module rtc_trim_cfg
    import rtc_trim_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DEL_W     = 10,
    parameter int DIV_RESET = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             win_start,
    output logic [DIV_W-1:0] div_act,
    output logic [DEL_W-1:0] del_shd
);

    localparam logic [DIV_W-1:0] DIV_INIT  = DIV_W'(DIV_RESET);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] div_shd;
    logic             div_wr_ok;

    // Divider writes below the floor are dropped
    assign div_wr_ok = wr_en && (wr_sel == SEL_DIVIDER) && (wr_data >= DIV_FLOOR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_shd <= DIV_INIT;
            del_shd <= '0;
        end else begin
            if (div_wr_ok) begin
                div_shd <= wr_data;
            end
            if (wr_en && (wr_sel == SEL_DELETE)) begin
                del_shd <= wr_data[DEL_W-1:0];
            end
        end
    end

    // Active divider follows the shadow only at a window start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_act <= DIV_INIT;
        end else if (win_start) begin
            div_act <= div_shd;
        end
    end

    // R7: active divider holds between window starts
    p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_start |=> $stable(div_act));

endmodule

// File: rtl/rtc_trim_ctrl.sv
module rtc_trim_ctrl
    import rtc_trim_pkg::*;
#(
    parameter int DEL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_start,
    input  logic             trim_en,
    input  logic [DEL_W-1:0] del_shd,
    output logic             cnt_en
);

    trim_state_e      state_q, state_d;
    logic [DEL_W-1:0] budget_q, budget_d;

    // Next-state and budget logic
    always_comb begin
        state_d  = state_q;
        budget_d = budget_q;
        unique case (state_q)
            TS_PASS: begin
                if (win_start && trim_en && (del_shd != '0)) begin
                    state_d  = TS_DELETE;
                    budget_d = del_shd;
                end
            end
            TS_DELETE: begin
                budget_d = budget_q - DEL_W'(1);
                if (budget_q == DEL_W'(1)) begin
                    state_d = TS_PASS;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= TS_PASS;
            budget_q <= '0;
        end else begin
            state_q  <= state_d;
            budget_q <= budget_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TS_PASS:   cnt_en = 1'b1;
            TS_DELETE: cnt_en = 1'b0;
        endcase
    end

    // R4: a window cannot close while cycles are being removed
    p_no_start_in_delete_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_DELETE) |-> !win_start);

    // R4: last budget unit returns to pass-through
    p_budget_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_DELETE && budget_q == DEL_W'(1)) |=> (state_q == TS_PASS));

    // R4: budget never runs out while deleting
    p_budget_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_DELETE) |-> (budget_q != '0));

    // R5: zero count means no deletion
    p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start && del_shd == '0) |=> (state_q == TS_PASS));

    // R6: trim disabled means no deletion
    p_trim_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start && !trim_en) |=> (state_q == TS_PASS));

endmodule

// File: rtl/rtc_div_core.sv
module rtc_div_core
    import rtc_trim_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int WIN_TICKS = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [DIV_W-1:0] div_act,
    output logic             win_start,
    output logic             hz_tick,
    output logic             win_mark
);

    localparam int WIN_W = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);

    logic [DIV_W-1:0] cnt_q;
    logic [WIN_W-1:0] win_q;
    logic             cnt_last;
    logic             win_last;
    logic             tick_now;

    assign cnt_last  = (cnt_q == (div_act - DIV_W'(1)));
    assign win_last  = (win_q == WIN_LAST);
    assign tick_now  = cnt_en && cnt_last;
    assign win_start = tick_now && win_last;

    // Input-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_en) begin
            cnt_q <= cnt_last ? '0 : cnt_q + DIV_W'(1);
        end
    end

    // Window tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (tick_now) begin
            win_q <= win_last ? '0 : win_q + WIN_W'(1);
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hz_tick  <= 1'b0;
            win_mark <= 1'b0;
        end else begin
            hz_tick  <= tick_now;
            win_mark <= win_start;
        end
    end

    // R10: counters in range
    p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div_act);
    p_win_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_q <= WIN_LAST);

    // R4: a deleted cycle does not advance the divider
    p_hold_on_delete_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_q));

    // R2: tick is a single-cycle pulse
    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hz_tick |=> !hz_tick);

    // R3: mark only together with a tick
    p_mark_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_mark |-> hz_tick);

    // R8: the active divider never falls below the floor
    p_div_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_act >= DIV_W'(MIN_DIV));

endmodule

// File: rtl/rtc_trim_div.sv
module rtc_trim_div
    import rtc_trim_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DEL_W     = 10,
    parameter int WIN_TICKS = 1023,
    parameter int DIV_RESET = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             trim_en,
    output logic             hz_tick,
    output logic             win_mark
);

    logic [DIV_W-1:0] div_act;
    logic [DEL_W-1:0] del_shd;
    logic             win_start;
    logic             cnt_en;

    rtc_trim_cfg #(
        .DIV_W     (DIV_W),
        .DEL_W     (DEL_W),
        .DIV_RESET (DIV_RESET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .win_start (win_start),
        .div_act   (div_act),
        .del_shd   (del_shd)
    );

    rtc_trim_ctrl #(
        .DEL_W     (DEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_start (win_start),
        .trim_en   (trim_en),
        .del_shd   (del_shd),
        .cnt_en    (cnt_en)
    );

    rtc_div_core #(
        .DIV_W     (DIV_W),
        .WIN_TICKS (WIN_TICKS)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .div_act   (div_act),
        .win_start (win_start),
        .hz_tick   (hz_tick),
        .win_mark  (win_mark)
    );

    // R1: quiet outputs while reset is held
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!hz_tick && !win_mark);
        end
    end

endmodule

// File: tb/test_rtc_trim_div.sv
module test_rtc_trim_div;

    localparam int DIV_W  = 16;
    localparam int DEL_W  = 10;
    localparam int WIN    = 4;
    localparam int DIVRST = 6;
    localparam int NWIN   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [DIV_W-1:0] wr_data = '0;
    logic             trim_en = 1'b1;
    logic             hz_tick;
    logic             win_mark;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int cyc = 0;
    int last_cyc = 0;
    int n_ticks = 0;
    int tick_gap [0:255];
    bit tick_mark [0:255];

    always #5 clk = ~clk;

    rtc_trim_div #(
        .DIV_W     (DIV_W),
        .DEL_W     (DEL_W),
        .WIN_TICKS (WIN),
        .DIV_RESET (DIVRST)
    ) i_rtc_trim_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .trim_en  (trim_en),
        .hz_tick  (hz_tick),
        .win_mark (win_mark)
    );

    // Tick recorder, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (win_mark && !hz_tick) begin
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL R3 mark without tick at cycle %0d: actual hz_tick=0 expected 1", cyc);
            end
            if (hz_tick && n_ticks < 256) begin
                tick_gap[n_ticks]  = cyc - last_cyc;
                tick_mark[n_ticks] = win_mark;
                last_cyc = cyc;
                n_ticks = n_ticks + 1;
            end
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_tick(input int idx);
        while (n_ticks <= idx) @(posedge clk);
    endtask

    task automatic reg_write(input logic sel, input logic [DIV_W-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        int cur_div;
        int cur_del;
        int shd_div;
        int shd_del;
        int base;
        int nd;
        int nl;
        bit ne;
        bit div_changed;

        // R1: outputs quiet under reset
        repeat (3) @(negedge clk);
        check_int("R1 hz_tick in reset", int'(hz_tick), 0);
        check_int("R1 win_mark in reset", int'(win_mark), 0);
        @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_int("R1 hz_tick after release", int'(hz_tick), 0);
        check_int("R1 win_mark after release", int'(win_mark), 0);

        // Window 0 runs on reset values: divider 6, no deletion (R1)
        cur_div = DIVRST;
        cur_del = 0;
        shd_div = DIVRST;
        shd_del = 0;

        for (int w = 0; w < NWIN; w++) begin
            base = w * WIN;
            wait_tick(base);
            check_int((w == 0) ? "R1 first tick spacing" : "R4 first tick spacing",
                      tick_gap[base], cur_div + cur_del);
            check_int("R3 no mark on first tick", int'(tick_mark[base]), 0);

            div_changed = 1'b0;
            if (w < NWIN - 1) begin
                // Settings for window w+1
                if (w < 16) begin
                    nd = 2 + (w / 4);
                    nl = w % 4;
                    ne = 1'b1;
                end else if (w == 16) begin
                    nd = 1;
                    nl = 2;
                    ne = 1'b0;
                end else if (w == 17) begin
                    nd = 0;
                    nl = 2;
                    ne = 1'b1;
                end else begin
                    nd = 7;
                    nl = 0;
                    ne = 1'b1;
                end
                trim_en = ne;
                reg_write(1'b0, DIV_W'(nd));
                // R9: upper data bits must not reach the 10-bit count
                reg_write(1'b1, DIV_W'(16'hFC00) | DIV_W'(nl));
                if (nd >= 2) begin
                    div_changed = (nd != shd_div);
                    shd_div = nd;
                end
                shd_del = nl;
            end

            for (int k = 1; k < WIN; k++) begin
                wait_tick(base + k);
                check_int(div_changed ? "R7 spacing unchanged mid-window" : "R2 tick spacing",
                          tick_gap[base + k], cur_div);
                check_int((k == WIN - 1) ? "R3 mark on closing tick" : "R3 no mark mid-window",
                          int'(tick_mark[base + k]), (k == WIN - 1) ? 1 : 0);
            end

            // Expected settings for the next window
            if (w == 16) begin
                check_int("R8 divider kept after write of 1", shd_div, 5);
            end
            cur_div = shd_div;
            cur_del = trim_en ? shd_del : 0;
            if (w == 16) begin
                check_int("R6 deletion off with trim disabled", cur_del, 0);
            end
        end

        check_int("R3 total ticks", n_ticks, NWIN * WIN);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R2 watchdog: actual %0d ticks expected %0d", n_ticks, NWIN * WIN);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule